// File: doc/BRIEF.md
# USB Device Endpoint Register Bank

This block is the software-visible register file of a USB device controller's endpoint logic. Software reaches it over a plain 32-bit register bus with a one-cycle registered read path. The transfer engine sits beside it and uses a set of pulse and event wires. The bank holds the device address, and can defer a new address until the status stage of the current control-IN transfer on endpoint 0 has finished.

Prime and flush requests follow a set-by-software, clear-by-engine handshake. In each 32-bit request vector, bits 15:0 stand for the receive (OUT) side of endpoints 0 to 15 and bits 31:16 for the transmit (IN) side of endpoints 0 to 15. Ready, completion and setup flags are raised by engine events. Completion and setup flags are cleared by software writing ones, and they drive a single interrupt line.

Sixteen endpoint control words carry the enable, transfer type and stall bits for each direction. They also carry toggle-reset bits that turn into a one-cycle strobe to the engine. Endpoint 0 is pinned as an enabled control endpoint.

Top module: `usbd_ep_regs`

## Requirements
- R1: A write to word 0 with bit 24 clear makes `dev_addr` equal to write bits 31:25 from the next cycle on.
- R2: A write to word 0 with bit 24 set leaves `dev_addr` unchanged and records the new address. Reading word 0 then returns the new address in bits 31:25 and a 1 in bit 24. On the first `ep0_in_done` pulse after that, `dev_addr` takes the new address and bit 24 reads 0.
- R3: Writing ones to the prime vector (word 1) sets those bits, and pulses `prime_go` for one cycle with exactly the newly set bits.
- R4: Writing 0 to a prime or flush bit never clears it. Writing 1 to a bit that is already set produces no `prime_go` or `flush_go` pulse for that bit.
- R5: A `prime_ack` bit clears the matching prime bit on the next clock edge.
- R6: The flush vector (word 2) behaves like the prime vector, with `flush_go` as its pulse. A `flush_done` bit clears the matching flush bit.
- R7: The ready vector (word 3) bits are set by `ep_ready_evt` and cleared by `flush_done`. Bus writes have no effect on them.
- R8: The completion vector (word 4, set by `xfer_done_evt`) and the setup vector (word 5, bits 15:0, set by `setup_evt`) are cleared by writing 1 to a bit. An event in the same cycle as a clear wins.
- R9: `irq` is high one cycle after any completion or setup bit is set, and low one cycle after all of them are clear.
- R10: Control word 16+n (n = 1..15) stores the following fields and reads them back: bit 23 TX enable, bits 19:18 TX type (0 control, 1 isochronous, 2 bulk, 3 interrupt), bit 16 TX stall, bit 7 RX enable, bits 3:2 RX type, bit 0 RX stall. Toggle-reset bits 22 and 6 always read 0. The fields also appear on the `ep_*` outputs; the type outputs hold two bits per endpoint, endpoint n at bits 2n+1:2n.
- R11: A write of 1 to bit 22 (TX) or bit 6 (RX) of control word 16+n (n ≥ 1) pulses bit n of `tog_rst_tx` or `tog_rst_rx` for exactly one cycle.
- R12: Control word 16 (endpoint 0) always reads both enables as 1 and both types as control. Only its stall bits are writable, and its toggle-reset bits produce no strobe.
- R13: After reset all vectors, the address, the stall bits, the non-zero endpoint enables, `irq` and all pulses are 0. Reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data valid on `reg_rdata` one cycle later |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| dev_addr | output | 7 | Active device address |
| prime_go | output | 32 | One-cycle pulse for newly primed directions |
| flush_go | output | 32 | One-cycle pulse for newly requested flushes |
| prime_ack | input | 32 | Engine took the descriptor; clears prime bits |
| flush_done | input | 32 | Engine finished flushing; clears flush and ready bits |
| ep_ready_evt | input | 32 | Engine marks a direction ready |
| xfer_done_evt | input | 32 | Engine handled a packet for a direction |
| setup_evt | input | 16 | Engine received a SETUP packet on an endpoint |
| ep0_in_done | input | 1 | Control-IN on endpoint 0 finished |
| tog_rst_tx | output | 16 | TX data-toggle reset strobe per endpoint |
| tog_rst_rx | output | 16 | RX data-toggle reset strobe per endpoint |
| ep_tx_en | output | 16 | TX enable per endpoint |
| ep_rx_en | output | 16 | RX enable per endpoint |
| ep_tx_stall | output | 16 | TX stall per endpoint |
| ep_rx_stall | output | 16 | RX stall per endpoint |
| ep_tx_type | output | 32 | TX type, two bits per endpoint |
| ep_rx_type | output | 32 | RX type, two bits per endpoint |
| irq | output | 1 | Interrupt: any completion or setup bit set |

## Verification
A prime or flush bit that fails to clear on acknowledge, or that clears on a written zero, shows up on the very next read of its vector. A spurious or repeated request pulse shows up on `prime_go` or `flush_go` in the cycle right after the write. A staging flag stuck high keeps `dev_addr` frozen after `ep0_in_done`, and one stuck low lets the address change early; either is visible one cycle after the event. A lost W1C or event priority error shows on the next read and, one cycle later, on `irq`. A wrong toggle flop shows as a strobe that is missing or longer than one cycle.

// File: rtl/usbd_ep_pkg.sv
package usbd_ep_pkg;
  localparam int EP_N = 16;
  localparam int DW   = 32;
  localparam int AW   = 6;
  localparam int EPW  = $clog2(EP_N);

  localparam logic [AW-1:0] A_ADDR  = 6'd0;
  localparam logic [AW-1:0] A_PRIME = 6'd1;
  localparam logic [AW-1:0] A_FLUSH = 6'd2;
  localparam logic [AW-1:0] A_READY = 6'd3;
  localparam logic [AW-1:0] A_CMPL  = 6'd4;
  localparam logic [AW-1:0] A_SETUP = 6'd5;
  localparam logic [AW-1:0] A_EPC   = 6'd16;

  localparam int B_STAGE   = 24;
  localparam int B_ADDR_LO = 25;
  localparam int B_TX_EN   = 23;
  localparam int B_TX_TOG  = 22;
  localparam int B_TX_TYP  = 18;
  localparam int B_TX_STL  = 16;
  localparam int B_RX_EN   = 7;
  localparam int B_RX_TOG  = 6;
  localparam int B_RX_TYP  = 2;
  localparam int B_RX_STL  = 0;

  typedef enum logic [1:0] {
    EPT_CTRL = 2'd0,
    EPT_ISO  = 2'd1,
    EPT_BULK = 2'd2,
    EPT_INTR = 2'd3
  } ep_type_e;
endpackage

// File: rtl/usbd_dev_addr.sv
module usbd_dev_addr #(
  parameter int ABITS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ABITS-1:0] wr_addr,
  input  logic             wr_stage,
  input  logic             ep0_in_done,
  output logic [ABITS-1:0] active,
  output logic [ABITS-1:0] shadow,
  output logic             staged
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      shadow <= '0;
      staged <= 1'b0;
    end else if (wr) begin
      shadow <= wr_addr;
      staged <= wr_stage;
      if (!wr_stage) active <= wr_addr;
    end else if (staged && ep0_in_done) begin
      active <= shadow;
      staged <= 1'b0;
    end
  end

  AST_ADDR_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_stage) |=> (active == $past(wr_addr)));  // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (staged && !ep0_in_done && !wr) |=> $stable(active));  // R2
  AST_ADDR_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (staged && ep0_in_done && !wr) |=> (!staged && active == $past(shadow)));  // R2
endmodule

// File: rtl/usbd_req_vec.sv
module usbd_req_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_wr,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q,
  output logic [W-1:0] go
);
  logic [W-1:0] fresh;

  assign fresh = set_wr ? (set_mask & ~q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      go <= '0;
    end else begin
      q  <= (q & ~clr_mask) | fresh;
      go <= fresh;
    end
  end

  AST_REQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~$past(q) & ~($past(set_wr) ? $past(set_mask) : '0)) == '0));  // R3
  AST_REQ_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~q & $past(q) & ~$past(clr_mask)) == '0));  // R4
  AST_REQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask & q) != '0) |=> ((q & $past(clr_mask & q)) == '0));  // R5
  AST_REQ_PULSE_NEW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((go & $past(q)) == '0));  // R4
endmodule

// File: rtl/usbd_evt_vec.sv
module usbd_evt_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | ev;
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((q & $past(ev)) == $past(ev)));  // R8
  AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~ev) != '0) |=> ((q & $past(clr & ~ev)) == '0));  // R8
endmodule

// File: rtl/usbd_epctl_bank.sv
module usbd_epctl_bank
  import usbd_ep_pkg::*;
#(
  parameter int NEP = 16,
  localparam int IW = $clog2(NEP)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [IW-1:0]         wr_idx,
  input  logic                  w_tx_en,
  input  logic                  w_tx_tog,
  input  logic [1:0]            w_tx_typ,
  input  logic                  w_tx_stl,
  input  logic                  w_rx_en,
  input  logic                  w_rx_tog,
  input  logic [1:0]            w_rx_typ,
  input  logic                  w_rx_stl,
  output logic [NEP-1:0]        tx_en,
  output logic [NEP-1:0]        rx_en,
  output logic [NEP-1:0]        tx_stl,
  output logic [NEP-1:0]        rx_stl,
  output logic [2*NEP-1:0]      tx_typ,
  output logic [2*NEP-1:0]      rx_typ,
  output logic [NEP-1:0]        tog_tx,
  output logic [NEP-1:0]        tog_rx,
  output logic [NEP-1:0][31:0]  word
);
  for (genvar g = 0; g < NEP; g++) begin : g_ep
    logic hit;
    assign hit = wr && (wr_idx == IW'(g));

    if (g == 0) begin : g_fixed
      always_ff @(posedge clk) begin
        if (rst) begin
          tx_stl[g] <= 1'b0;
          rx_stl[g] <= 1'b0;
        end else if (hit) begin
          tx_stl[g] <= w_tx_stl;
          rx_stl[g] <= w_rx_stl;
        end
      end
      assign tx_en[g]         = 1'b1;
      assign rx_en[g]         = 1'b1;
      assign tx_typ[2*g +: 2] = EPT_CTRL;
      assign rx_typ[2*g +: 2] = EPT_CTRL;
      assign tog_tx[g]        = 1'b0;
      assign tog_rx[g]        = 1'b0;
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (rst) begin
          tx_en[g]         <= 1'b0;
          rx_en[g]         <= 1'b0;
          tx_stl[g]        <= 1'b0;
          rx_stl[g]        <= 1'b0;
          tx_typ[2*g +: 2] <= EPT_CTRL;
          rx_typ[2*g +: 2] <= EPT_CTRL;
          tog_tx[g]        <= 1'b0;
          tog_rx[g]        <= 1'b0;
        end else begin
          tog_tx[g] <= hit && w_tx_tog;
          tog_rx[g] <= hit && w_rx_tog;
          if (hit) begin
            tx_en[g]         <= w_tx_en;
            rx_en[g]         <= w_rx_en;
            tx_stl[g]        <= w_tx_stl;
            rx_stl[g]        <= w_rx_stl;
            tx_typ[2*g +: 2] <= w_tx_typ;
            rx_typ[2*g +: 2] <= w_rx_typ;
          end
        end
      end

      AST_TOG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tog_tx[g] && !hit) |=> !tog_tx[g]);  // R11
    end

    assign word[g] = {8'd0, tx_en[g], 3'd0, tx_typ[2*g +: 2], 1'b0, tx_stl[g],
                      8'd0, rx_en[g], 3'd0, rx_typ[2*g +: 2], 1'b0, rx_stl[g]};
  end

  AST_EP0_PINNED: assert property (@(posedge clk) disable iff (rst)
    (tx_en[0] && rx_en[0] && tx_typ[1:0] == 2'd0 && rx_typ[1:0] == 2'd0
     && !tog_tx[0] && !tog_rx[0]));  // R12
endmodule

// File: rtl/usbd_ep_regs.sv
module usbd_ep_regs
  import usbd_ep_pkg::*;
#(
  parameter int NEP = EP_N,
  localparam int VW = 2 * NEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [6:0]        dev_addr,
  output logic [VW-1:0]     prime_go,
  output logic [VW-1:0]     flush_go,
  input  logic [VW-1:0]     prime_ack,
  input  logic [VW-1:0]     flush_done,
  input  logic [VW-1:0]     ep_ready_evt,
  input  logic [VW-1:0]     xfer_done_evt,
  input  logic [NEP-1:0]    setup_evt,
  input  logic              ep0_in_done,
  output logic [NEP-1:0]    tog_rst_tx,
  output logic [NEP-1:0]    tog_rst_rx,
  output logic [NEP-1:0]    ep_tx_en,
  output logic [NEP-1:0]    ep_rx_en,
  output logic [NEP-1:0]    ep_tx_stall,
  output logic [NEP-1:0]    ep_rx_stall,
  output logic [VW-1:0]     ep_tx_type,
  output logic [VW-1:0]     ep_rx_type,
  output logic              irq
);
  localparam int IW = $clog2(NEP);
  localparam logic [AW-IW-1:0] EPC_SEL = A_EPC[AW-1:IW];

  logic wr_addr_reg, wr_prime, wr_flush, wr_cmpl, wr_setup, wr_epc;
  assign wr_addr_reg = reg_we && (reg_addr == A_ADDR);
  assign wr_prime    = reg_we && (reg_addr == A_PRIME);
  assign wr_flush    = reg_we && (reg_addr == A_FLUSH);
  assign wr_cmpl     = reg_we && (reg_addr == A_CMPL);
  assign wr_setup    = reg_we && (reg_addr == A_SETUP);
  assign wr_epc      = reg_we && (reg_addr[AW-1:IW] == EPC_SEL);

  logic [6:0] shadow_addr;
  logic       staged;

  usbd_dev_addr #(.ABITS(7)) u_addr (
    .clk(clk), .rst(rst), .wr(wr_addr_reg),
    .wr_addr(reg_wdata[B_ADDR_LO +: 7]), .wr_stage(reg_wdata[B_STAGE]),
    .ep0_in_done(ep0_in_done), .active(dev_addr), .shadow(shadow_addr), .staged(staged)
  );

  logic [VW-1:0] prime_q, flush_q, ready_q, cmpl_q;
  logic [NEP-1:0] setup_q;

  usbd_req_vec #(.W(VW)) u_prime (
    .clk(clk), .rst(rst), .set_wr(wr_prime), .set_mask(reg_wdata[VW-1:0]),
    .clr_mask(prime_ack), .q(prime_q), .go(prime_go)
  );

  usbd_req_vec #(.W(VW)) u_flush (
    .clk(clk), .rst(rst), .set_wr(wr_flush), .set_mask(reg_wdata[VW-1:0]),
    .clr_mask(flush_done), .q(flush_q), .go(flush_go)
  );

  usbd_evt_vec #(.W(VW)) u_ready (
    .clk(clk), .rst(rst), .ev(ep_ready_evt), .clr(flush_done), .q(ready_q)
  );

  usbd_evt_vec #(.W(VW)) u_cmpl (
    .clk(clk), .rst(rst), .ev(xfer_done_evt),
    .clr(wr_cmpl ? reg_wdata[VW-1:0] : '0), .q(cmpl_q)
  );

  usbd_evt_vec #(.W(NEP)) u_setup (
    .clk(clk), .rst(rst), .ev(setup_evt),
    .clr(wr_setup ? reg_wdata[NEP-1:0] : '0), .q(setup_q)
  );

  logic [NEP-1:0][31:0] epc_word;

  usbd_epctl_bank #(.NEP(NEP)) u_epc (
    .clk(clk), .rst(rst), .wr(wr_epc), .wr_idx(reg_addr[IW-1:0]),
    .w_tx_en(reg_wdata[B_TX_EN]), .w_tx_tog(reg_wdata[B_TX_TOG]),
    .w_tx_typ(reg_wdata[B_TX_TYP +: 2]), .w_tx_stl(reg_wdata[B_TX_STL]),
    .w_rx_en(reg_wdata[B_RX_EN]), .w_rx_tog(reg_wdata[B_RX_TOG]),
    .w_rx_typ(reg_wdata[B_RX_TYP +: 2]), .w_rx_stl(reg_wdata[B_RX_STL]),
    .tx_en(ep_tx_en), .rx_en(ep_rx_en), .tx_stl(ep_tx_stall), .rx_stl(ep_rx_stall),
    .tx_typ(ep_tx_type), .rx_typ(ep_rx_type), .tog_tx(tog_rst_tx), .tog_rx(tog_rst_rx),
    .word(epc_word)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_ADDR) begin
      rd_mux[B_ADDR_LO +: 7] = shadow_addr;
      rd_mux[B_STAGE]        = staged;
    end else if (reg_addr == A_PRIME) rd_mux[VW-1:0]  = prime_q;
    else if (reg_addr == A_FLUSH)     rd_mux[VW-1:0]  = flush_q;
    else if (reg_addr == A_READY)     rd_mux[VW-1:0]  = ready_q;
    else if (reg_addr == A_CMPL)      rd_mux[VW-1:0]  = cmpl_q;
    else if (reg_addr == A_SETUP)     rd_mux[NEP-1:0] = setup_q;
    else if (reg_addr[AW-1:IW] == EPC_SEL) rd_mux = epc_word[reg_addr[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_re) reg_rdata <= rd_mux;
      irq <= (|cmpl_q) || (|setup_q);
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((cmpl_q != '0) || (setup_q != '0)) |=> irq);  // R9
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    ((cmpl_q == '0) && (setup_q == '0)) |=> !irq);  // R9
  AST_READY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ep_ready_evt == '0) |=> ((ready_q & ~$past(ready_q)) == '0));  // R7
endmodule

// File: tb/usbd_ep_regs_test.sv
module usbd_ep_regs_test;
  import usbd_ep_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 0, reg_re = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [6:0]  dev_addr;
  logic [31:0] prime_go, flush_go, ep_tx_type, ep_rx_type;
  logic [31:0] prime_ack = '0, flush_done = '0, ep_ready_evt = '0, xfer_done_evt = '0;
  logic [15:0] setup_evt = '0;
  logic        ep0_in_done = 0;
  logic [15:0] tog_rst_tx, tog_rst_rx, ep_tx_en, ep_rx_en, ep_tx_stall, ep_rx_stall;
  logic        irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usbd_ep_regs uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_addr(dev_addr),
    .prime_go(prime_go), .flush_go(flush_go), .prime_ack(prime_ack),
    .flush_done(flush_done), .ep_ready_evt(ep_ready_evt), .xfer_done_evt(xfer_done_evt),
    .setup_evt(setup_evt), .ep0_in_done(ep0_in_done), .tog_rst_tx(tog_rst_tx),
    .tog_rst_rx(tog_rst_rx), .ep_tx_en(ep_tx_en), .ep_rx_en(ep_rx_en),
    .ep_tx_stall(ep_tx_stall), .ep_rx_stall(ep_rx_stall), .ep_tx_type(ep_tx_type),
    .ep_rx_type(ep_rx_type), .irq(irq)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_pend <= reg_re;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    reg_re = 1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk("R13 dev_addr", {25'd0, dev_addr}, 32'd0);
    chk("R13 irq", {31'd0, irq}, 32'd0);
    chk("R13 stall", {16'd0, ep_tx_stall}, 32'd0);
    chk("R13 tx_en", {16'd0, ep_tx_en}, 32'h1);
    rd(A_PRIME, 32'd0, "R13 prime");
    rd(A_ADDR, 32'd0, "R13 addr");
    rd(6'd9, 32'd0, "R13 unmapped");
    rd(6'd19, 32'd0, "R13 epc3");

    // R1 immediate address
    wr(A_ADDR, 32'h1400_0000);
    chk("R1 dev_addr", {25'd0, dev_addr}, 32'h0A);
    rd(A_ADDR, 32'h1400_0000, "R1 readback");

    // R2 staged address
    wr(A_ADDR, 32'h6700_0000);
    chk("R2 held", {25'd0, dev_addr}, 32'h0A);
    idle(2);
    chk("R2 still held", {25'd0, dev_addr}, 32'h0A);
    rd(A_ADDR, 32'h6700_0000, "R2 staged readback");
    ep0_in_done = 1; @(negedge clk); ep0_in_done = 0;
    chk("R2 committed", {25'd0, dev_addr}, 32'h33);
    rd(A_ADDR, 32'h6600_0000, "R2 flag cleared");

    // R3 / R4 / R5 prime
    wr(A_PRIME, 32'h0001_0002);
    chk("R3 prime_go", prime_go, 32'h0001_0002);
    @(negedge clk);
    chk("R3 prime_go single", prime_go, 32'd0);
    wr(A_PRIME, 32'h0001_0003);
    chk("R4 only new bit pulses", prime_go, 32'h0000_0001);
    wr(A_PRIME, 32'd0);
    chk("R4 no pulse on zero", prime_go, 32'd0);
    rd(A_PRIME, 32'h0001_0003, "R4 zero keeps");
    prime_ack = 32'h0000_0002; @(negedge clk); prime_ack = '0;
    rd(A_PRIME, 32'h0001_0001, "R5 ack clears");

    // R6 / R7 flush and ready
    wr(A_FLUSH, 32'h0000_0004);
    chk("R6 flush_go", flush_go, 32'h4);
    ep_ready_evt = 32'h0002_0004; @(negedge clk); ep_ready_evt = '0;
    wr(A_READY, 32'd0);
    rd(A_READY, 32'h0002_0004, "R7 ready set, write ignored");
    flush_done = 32'h4; @(negedge clk); flush_done = '0;
    rd(A_FLUSH, 32'd0, "R6 done clears");
    rd(A_READY, 32'h0002_0000, "R7 flush clears ready");

    // R8 / R9 completion, setup, irq
    xfer_done_evt = 32'h0003_0001; @(negedge clk); xfer_done_evt = '0;
    @(negedge clk);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    wr(A_CMPL, 32'h1);
    rd(A_CMPL, 32'h0003_0000, "R8 w1c partial");
    xfer_done_evt = 32'h0001_0000;
    wr(A_CMPL, 32'hFFFF_FFFF);
    xfer_done_evt = '0;
    rd(A_CMPL, 32'h0001_0000, "R8 event wins");
    wr(A_CMPL, 32'hFFFF_FFFF);
    setup_evt = 16'h0008; @(negedge clk); setup_evt = '0;
    rd(A_SETUP, 32'h8, "R8 setup set");
    wr(A_SETUP, 32'h8);
    idle(1);
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);
    rd(A_SETUP, 32'h0, "R8 setup cleared");

    // R10 / R11 endpoint control
    wr(6'd19, 32'h00C9_00CD);
    chk("R11 tx strobe", {16'd0, tog_rst_tx}, 32'h8);
    chk("R11 rx strobe", {16'd0, tog_rst_rx}, 32'h8);
    @(negedge clk);
    chk("R11 strobe ends", {tog_rst_tx, tog_rst_rx}, 32'd0);
    rd(6'd19, 32'h0089_008D, "R10 readback");
    chk("R10 tx type", {30'd0, ep_tx_type[7:6]}, 32'd2);
    chk("R10 rx type", {30'd0, ep_rx_type[7:6]}, 32'd3);
    chk("R10 en/stall", {ep_tx_en[3], ep_rx_en[3], ep_tx_stall[3], ep_rx_stall[3]}, 32'hF);

    // R12 endpoint 0
    wr(6'd16, 32'h00C9_00CD);
    chk("R12 no strobe", {tog_rst_tx, tog_rst_rx}, 32'd0);
    rd(6'd16, 32'h0081_0081, "R12 stall only");
    wr(6'd16, 32'd0);
    rd(6'd16, 32'h0080_0080, "R12 enables pinned");

    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule